// File: doc/BRIEF.md
# Bus traffic performance monitor

This block sits beside one on-chip bus port and counts the traffic that passes through it. Each cycle it receives two strobes, one for a read data beat and one for a write data beat. It keeps a free-running cycle counter and four event counters. Each event counter has its own selector that picks which traffic it counts.

Software controls the block through a plain 32-bit register port with separate read and write enables, a byte address and data. A typical session selects the events, turns on the wanted counters and sets the global run bit. It later clears the run bit, so that every counter stops on the same edge, and then reads a coherent snapshot. When a counter wraps, a sticky flag is set, and a level interrupt reports the flags that software has armed.

Register map, with byte offsets and address bits [1:0] ignored:
- 0x00: control
- 0x04 and 0x08: counter enable set and clear
- 0x0C and 0x10: interrupt enable set and clear
- 0x14: wrap flags
- 0x18: cycle counter
- 0x20 + 4*i: event select for counter i
- 0x30 + 4*i: count for counter i (0x3C is the low part of counter 3)
- 0x40: high part of counter 3

Top module: `bpm_monitor`

## Requirements
- R1: After reset, every counter, every enable, every flag, every select and the control register read 0, and irq is low.
- R2: The counter enables use one bit per counter: bit 31 for the cycle counter and bits 0 to 3 for event counters 0 to 3. A write to 0x04 sets the bits written as 1, and a write to 0x08 clears them. Bits written as 0 keep their value, other bit positions are ignored, and both addresses read back the current enables.
- R3: A counter advances on a clock edge only when all three of these hold: control bit 0 (global run) is 1, the start-mode field in control bits [5:4] is 0 (manual), and the counter's own enable bit is 1. Otherwise it holds its value. The cycle counter adds 1 per counting cycle.
- R4: Bits [1:0] of an event select register choose what the counter adds each counting cycle. Code 0 adds nothing, 1 adds the read beat strobe, 2 adds the write beat strobe, and 3 adds both, so the counter can gain 2 in one cycle.
- R5: Writing 1 to control bit 1 zeroes all event counters, and writing 1 to control bit 2 zeroes the cycle counter. The bit reads as 1 for the one cycle after the write and then clears itself. The zeroing happens on that next edge and takes priority over counting.
- R6: Event counters 0 to 2 are CNT_W bits wide. Counter 3 is WIDE_W bits wide. Offset 0x3C returns its low CNT_W bits and offset 0x40 returns its upper WIDE_W-CNT_W bits, right-aligned.
- R7: A counter that wraps past its maximum sets its flag at 0x14, using the same bit layout as R2. Writing 1 to a flag bit clears it. A wrap on the same edge as the clear wins.
- R8: Interrupt enables use the R2 bit layout, with set at 0x0C and clear at 0x10. irq is high exactly when some flag bit and its interrupt enable bit are both 1.
- R9: Reads with rd_en low, reads of unmapped addresses and reads of write-only positions return 0. Writes to the counter and unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from addr |
| rd_beat | input | 1 | A read data beat was seen this cycle |
| wr_beat | input | 1 | A write data beat was seen this cycle |
| irq | output | 1 | Level interrupt from armed wrap flags |

## Verification
The counters are driven with random beat patterns: reads only, writes only, both at once, and idle cycles. These are mixed with random writes to every register, so the four select codes, the run gating, the start-mode field and the clear bits all interact. The bench instance uses narrow counters, so that wraps, flag setting and clearing, and the split of the wide counter into high and low parts happen many times within a run. One directed phase drives both strobes on every cycle with select code 3. This tells a counter that adds two per cycle apart from one that adds only one, and it carries counter 3 past its low part into the high register.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int NUM_EVT = 4;
  localparam int CYC_BIT = 31;
  localparam logic [1:0] MODE_MANUAL = 2'd0;

  localparam int W_CTRL   = 0;
  localparam int W_ENSET  = 1;
  localparam int W_ENCLR  = 2;
  localparam int W_IESET  = 3;
  localparam int W_IECLR  = 4;
  localparam int W_FLAG   = 5;
  localparam int W_CYC    = 6;
  localparam int W_SEL0   = 8;
  localparam int W_CNT0   = 12;
  localparam int W_CNT3HI = 16;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RD   = 2'd1,
    SEL_WR   = 2'd2,
    SEL_BOTH = 2'd3
  } evt_sel_e;

  typedef struct packed {
    logic                          run;
    logic                          cycEn;
    logic [NUM_EVT-1:0]            evtEn;
    logic                          clrEvt;
    logic                          clrCyc;
    logic [NUM_EVT-1:0][1:0]       sel;
  } strobe_t;
endpackage

// File: rtl/bpm_datapath.sv
module bpm_datapath
  import bpm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 40,
  parameter int CYC_W  = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  input  logic                           rdBeat,
  input  logic                           wrBeat,
  output logic [CYC_W-1:0]               cycCnt,
  output logic [NUM_EVT-1:0][WIDE_W-1:0] evtCnt,
  output logic                           cycWrap,
  output logic [NUM_EVT-1:0]             evtWrap
);
  logic [CYC_W:0] cycSum;
  logic           cycGo;

  assign cycGo   = strb.run && strb.cycEn;
  assign cycSum  = {1'b0, cycCnt} + {{CYC_W{1'b0}}, 1'b1};
  assign cycWrap = cycGo && !strb.clrCyc && cycSum[CYC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cycCnt <= '0;
    else if (strb.clrCyc) cycCnt <= '0;
    else if (cycGo)       cycCnt <= cycSum[CYC_W-1:0];
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    localparam int W = (i == NUM_EVT-1) ? WIDE_W : CNT_W;
    logic [W-1:0] cnt;
    logic [W:0]   sum;
    logic [1:0]   step;
    logic         go;

    always_comb begin
      unique case (evt_sel_e'(strb.sel[i]))
        SEL_RD:   step = {1'b0, rdBeat};
        SEL_WR:   step = {1'b0, wrBeat};
        SEL_BOTH: step = {1'b0, rdBeat} + {1'b0, wrBeat};
        default:  step = 2'd0;
      endcase
    end

    assign go         = strb.run && strb.evtEn[i];
    assign sum        = {1'b0, cnt} + (W+1)'(step);
    assign evtWrap[i] = go && !strb.clrEvt && sum[W];
    assign evtCnt[i]  = WIDE_W'(cnt);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cnt <= '0;
      else if (strb.clrEvt) cnt <= '0;
      else if (go)          cnt <= sum[W-1:0];
    end
  end

  // R3
  cyc_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cycGo && !strb.clrCyc) |=> $stable(cycCnt));

  // R5
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEvt |=> (evtCnt[0] == '0 && evtCnt[NUM_EVT-1] == '0));

  // R4
  evt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrEvt |=> (CNT_W'(evtCnt[0][CNT_W-1:0] - $past(evtCnt[0][CNT_W-1:0])) <= CNT_W'(2)));
endmodule

// File: rtl/bpm_ctrl.sv
module bpm_ctrl
  import bpm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 40,
  parameter int CYC_W  = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [31:0]                    wrData,
  output logic [31:0]                    rdData,
  output logic                           irq,
  output strobe_t                        strb,
  input  logic [CYC_W-1:0]               cycCnt,
  input  logic [NUM_EVT-1:0][WIDE_W-1:0] evtCnt,
  input  logic                           cycWrap,
  input  logic [NUM_EVT-1:0]             evtWrap
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [31:0] BIT_MASK = (32'd1 << CYC_BIT) | ((32'd1 << NUM_EVT) - 32'd1);

  logic [WORD_W-1:0]       wordIdx;
  logic                    glbEn, rstEvtPend, rstCycPend;
  logic [1:0]              mode;
  logic [31:0]             cntEn, intEn, flags, wrMask, wrapBits;
  logic [NUM_EVT-1:0][1:0] sel;

  assign wordIdx  = addr[ADDR_W-1:2];
  assign wrMask   = wrData & BIT_MASK;
  assign wrapBits = (32'(cycWrap) << CYC_BIT) | 32'(evtWrap);

  function automatic logic hit(input logic [WORD_W-1:0] idx, input int w);
    return idx == WORD_W'(w);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbEn <= 1'b0; mode <= MODE_MANUAL;
      rstEvtPend <= 1'b0; rstCycPend <= 1'b0;
      cntEn <= '0; intEn <= '0; flags <= '0; sel <= '0;
    end else begin
      rstEvtPend <= 1'b0;
      rstCycPend <= 1'b0;
      flags      <= (flags & ~((wrEn && hit(wordIdx, W_FLAG)) ? wrMask : 32'd0)) | wrapBits;
      if (wrEn) begin
        if (hit(wordIdx, W_CTRL)) begin
          glbEn      <= wrData[0];
          rstEvtPend <= wrData[1];
          rstCycPend <= wrData[2];
          mode       <= wrData[5:4];
        end
        if (hit(wordIdx, W_ENSET)) cntEn <= cntEn | wrMask;
        if (hit(wordIdx, W_ENCLR)) cntEn <= cntEn & ~wrMask;
        if (hit(wordIdx, W_IESET)) intEn <= intEn | wrMask;
        if (hit(wordIdx, W_IECLR)) intEn <= intEn & ~wrMask;
        for (int i = 0; i < NUM_EVT; i++)
          if (hit(wordIdx, W_SEL0 + i)) sel[i] <= wrData[1:0];
      end
    end
  end

  always_comb begin
    strb.run    = glbEn && (mode == MODE_MANUAL);
    strb.cycEn  = cntEn[CYC_BIT];
    strb.evtEn  = cntEn[NUM_EVT-1:0];
    strb.clrEvt = rstEvtPend;
    strb.clrCyc = rstCycPend;
    strb.sel    = sel;
  end

  assign irq = |(flags & intEn);

  always_comb begin
    rdData = 32'd0;
    if (rdEn) begin
      if (hit(wordIdx, W_CTRL))
        rdData = {26'd0, mode, 1'b0, rstCycPend, rstEvtPend, glbEn};
      if (hit(wordIdx, W_ENSET) || hit(wordIdx, W_ENCLR)) rdData = cntEn;
      if (hit(wordIdx, W_IESET) || hit(wordIdx, W_IECLR)) rdData = intEn;
      if (hit(wordIdx, W_FLAG))   rdData = flags;
      if (hit(wordIdx, W_CYC))    rdData = 32'(cycCnt);
      if (hit(wordIdx, W_CNT3HI)) rdData = 32'(evtCnt[NUM_EVT-1][WIDE_W-1:CNT_W]);
      for (int i = 0; i < NUM_EVT; i++) begin
        if (hit(wordIdx, W_SEL0 + i)) rdData = {30'd0, sel[i]};
        if (hit(wordIdx, W_CNT0 + i)) rdData = 32'(evtCnt[i][CNT_W-1:0]);
      end
    end
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hit(wordIdx, W_ENSET)) |=> ((cntEn & $past(wrMask)) == $past(wrMask)));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtWrap[0] |=> flags[0]);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags == 32'd0) |-> !irq);
endmodule

// File: rtl/bpm_monitor.sv
module bpm_monitor
  import bpm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 40,
  parameter int CYC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              rd_beat,
  input  logic              wr_beat,
  output logic              irq
);
  strobe_t                        strb;
  logic [CYC_W-1:0]               cycCnt;
  logic [NUM_EVT-1:0][WIDE_W-1:0] evtCnt;
  logic                           cycWrap;
  logic [NUM_EVT-1:0]             evtWrap;

  bpm_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIDE_W(WIDE_W), .CYC_W(CYC_W)) u_ctrl (
    .clk(clk), .rstN(rst_n), .wrEn(wr_en), .rdEn(rd_en), .addr(addr),
    .wrData(wr_data), .rdData(rd_data), .irq(irq), .strb(strb),
    .cycCnt(cycCnt), .evtCnt(evtCnt), .cycWrap(cycWrap), .evtWrap(evtWrap));

  bpm_datapath #(.CNT_W(CNT_W), .WIDE_W(WIDE_W), .CYC_W(CYC_W)) u_dp (
    .clk(clk), .rstN(rst_n), .strb(strb), .rdBeat(rd_beat), .wrBeat(wr_beat),
    .cycCnt(cycCnt), .evtCnt(evtCnt), .cycWrap(cycWrap), .evtWrap(evtWrap));
endmodule

// File: tb/bpm_monitor_tb.sv
module bpm_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;
  localparam int WIDE_W = 12;
  localparam int CYC_W  = 10;
  localparam logic [31:0] MASK = 32'h8000_000F;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic rd_beat = 1'b0, wr_beat = 1'b0, irq;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;

  int vectors = 0, fails = 0;
  bit done = 0;

  bit mGlb, mRstE, mRstC;
  logic [1:0] mMode;
  logic [31:0] mEn, mIe, mFlag;
  logic [1:0] mSel [4];
  longint mCyc;
  longint mCnt [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  bpm_monitor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIDE_W(WIDE_W), .CYC_W(CYC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_beat(rd_beat), .wr_beat(wr_beat), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input int w);
    case (w)
      0: return "R5";
      1, 2: return "R2";
      3, 4: return "R8";
      5: return "R7";
      6, 12, 13, 14: return "R3";
      8, 9, 10, 11: return "R4";
      15, 16: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] mRead(input int w);
    case (w)
      0: return {26'd0, mMode, 1'b0, mRstC, mRstE, mGlb};
      1, 2: return mEn;
      3, 4: return mIe;
      5: return mFlag;
      6: return 32'(mCyc);
      8, 9, 10, 11: return {30'd0, mSel[w-8]};
      12, 13, 14: return 32'(mCnt[w-12]);
      15: return 32'(mCnt[3] % (64'd1 << CNT_W));
      16: return 32'(mCnt[3] >> CNT_W);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic mIrq();
    return |(mFlag & mIe);
  endfunction

  task automatic mReset();
    mGlb = 0; mRstE = 0; mRstC = 0; mMode = 0; mEn = 0; mIe = 0; mFlag = 0; mCyc = 0;
    for (int i = 0; i < 4; i++) begin mSel[i] = 0; mCnt[i] = 0; end
  endtask

  task automatic mStep(input bit we, input int w, input logic [31:0] d, input bit rb, input bit wb);
    bit run;
    logic [31:0] wraps;
    run = mGlb && (mMode == 2'd0);
    wraps = 0;
    if (mRstC) mCyc = 0;
    else if (run && mEn[31]) begin
      mCyc++;
      if (mCyc >= (64'd1 << CYC_W)) begin mCyc -= (64'd1 << CYC_W); wraps[31] = 1; end
    end
    for (int i = 0; i < 4; i++) begin
      longint lim, st;
      lim = 64'd1 << ((i == 3) ? WIDE_W : CNT_W);
      st = (mSel[i] == 2'd1) ? rb : (mSel[i] == 2'd2) ? wb : (mSel[i] == 2'd3) ? (rb + wb) : 0;
      if (mRstE) mCnt[i] = 0;
      else if (run && mEn[i]) begin
        mCnt[i] += st;
        if (mCnt[i] >= lim) begin mCnt[i] -= lim; wraps[i] = 1; end
      end
    end
    mRstE = 0; mRstC = 0;
    if (we) begin
      case (w)
        0: begin mGlb = d[0]; mRstE = d[1]; mRstC = d[2]; mMode = d[5:4]; end
        1: mEn = mEn | (d & MASK);
        2: mEn = mEn & ~(d & MASK);
        3: mIe = mIe | (d & MASK);
        4: mIe = mIe & ~(d & MASK);
        5: mFlag = mFlag & ~(d & MASK);
        8, 9, 10, 11: mSel[w-8] = d[1:0];
        default: ;
      endcase
    end
    mFlag = mFlag | wraps;
  endtask

  task automatic cycleOp(input bit we, input int w, input logic [31:0] d,
                         input bit rb, input bit wb, input int rw, input bit re);
    @(negedge clk);
    wr_en = 1'b0; addr = ADDR_W'(rw * 4); rd_en = re;
    #1;
    chk(reqOf(rw), rd_data, re ? mRead(rw) : 32'd0);
    chk("R8", 32'(irq), 32'(mIrq()));
    rd_en = 1'b0; addr = ADDR_W'(w * 4); wr_en = we; wr_data = d;
    rd_beat = rb; wr_beat = wb;
    @(posedge clk);
    mStep(we, w, d, rb, wb);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int wlist [18] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 16, 20};
    void'($urandom(32'd4711));
    mReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every readable register
    for (int w = 0; w < 17; w++) begin
      @(negedge clk);
      addr = ADDR_W'(w * 4); rd_en = 1'b1;
      #1;
      chk("R1", rd_data, 32'd0);
      chk("R1", 32'(irq), 32'd0);
      rd_en = 1'b0;
    end
    // R4/R6 directed: counter 3 counts both beats, runs past its low part
    cycleOp(1, 11, 32'd3, 0, 0, 0, 1);
    cycleOp(1, 8, 32'd1, 0, 0, 0, 1);
    cycleOp(1, 1, 32'hFFFF_FFFF, 0, 0, 1, 1);
    cycleOp(1, 3, 32'h0000_0008, 0, 0, 1, 1);
    cycleOp(1, 0, 32'd1, 0, 0, 3, 1);
    for (int k = 0; k < 2100; k++)
      cycleOp(0, 0, 0, 1, 1, (k % 2) ? 16 : 15, 1);
    cycleOp(1, 0, 32'd0, 0, 0, 5, 1);
    chk("R6", mRead(16), 32'd0);
    cycleOp(0, 0, 0, 1, 1, 16, 1);
    cycleOp(0, 0, 0, 1, 1, 15, 1);
    cycleOp(0, 0, 0, 0, 0, 12, 1);
    // R7: clear all flags, then read back
    cycleOp(1, 5, 32'hFFFF_FFFF, 0, 0, 5, 1);
    cycleOp(0, 0, 0, 0, 0, 5, 1);
    // Random phase
    for (int k = 0; k < 6000; k++) begin
      int r, w, rw;
      logic [31:0] d;
      bit we;
      r = $urandom_range(0, 99);
      we = (r < 25);
      w = wlist[$urandom_range(0, 17)];
      d = $urandom();
      if (w == 0) begin
        d = 32'd0;
        d[0] = ($urandom_range(0, 9) < 8);
        d[1] = ($urandom_range(0, 9) == 0);
        d[2] = ($urandom_range(0, 9) == 0);
        d[5:4] = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      end
      if (w == 2 || w == 4 || w == 5)
        if ($urandom_range(0, 3) != 0) d = d & 32'h0000_0003;
      rw = wlist[$urandom_range(0, 17)];
      cycleOp(we, w, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              rw, ($urandom_range(0, 9) != 0));
    end
    cycleOp(0, 0, 0, 0, 0, 0, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule